// File: doc/BRIEF.md
# Parallel Device Bus Read Sequencer

This block runs read cycles on a multiplexed parallel bus. The bus serves asynchronous NOR flash, SRAM or FPGA-style devices. Five chip-select lines each have a 32-bit timing register, which is programmed through a small write port. An internal requester hands over a chip-select index, a byte address and a burst length. The block then performs the whole read:

- It drives the address onto the shared address/data lines while pulsing the address latch strobe.
- It lowers the selected chip select.
- It lowers output enable after a programmable setup delay.
- It samples the returned data at programmed instants.
- It releases the lines for a programmable turnaround interval before another read may start.

Each sample is returned as one response word, masked to the device width (8, 16 or 32 bits). The low address bits advance by the device width after each beat of a burst.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request stays pending, with its fields held, until it is accepted, and it is accepted on the edge where `req_valid` and `req_ready` are both high. The response side has no back-pressure: the external bus cannot be stalled, so the consumer must take each `rsp_valid` word in the cycle it appears.

Top module: `pbus_rd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, all chip selects and output enable are high (inactive), the address strobe and bus drive enable are 0, and no response is valid. Every timing register resets to 0x40840182.
- R2: An accepted request produces a single address cycle in the next clock. In that cycle `bus_ale` and `bus_ad_oe` are 1, `bus_ad_out` carries the zero-extended request address, and exactly the requested chip select is low. `bus_ad_oe` is never 1 outside that cycle, and `req_ready` is 1 only when no chip select, output enable or strobe is active.
- R3: The first data sample is taken in the cycle that lies `first`−2 cycles after the address cycle. Here `first` is bits [11:6] of the selected register, and a value below 6 is used as 6.
- R4: A burst has `req_len`+1 beats, and the samples are `next` cycles apart. Here `next` is bits [22:17], and a value below 2 is used as 2.
- R5: Output enable falls `setup` cycles after chip select falls, with `setup` taken from bits [16:12]. The value 0 means both fall in the address cycle. The setup value never moves any sample.
- R6: Output enable rises in the cycle after the last sample. The chip select rises `hold` cycles after the last sample, with `hold` taken from bits [27:23]. A `hold` of 0 or 1 means it rises together with output enable.
- R7: After the last sample of a read, at least max(`turn`, `hold`) cycles pass before the next address cycle. Here `turn` is bits [5:0], and a value below 2 is used as 2. When a request is already waiting, the next address cycle comes exactly that many cycles plus one after the last sample.
- R8: The width field in bits [31:30] encodes 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. Response data keeps only the low 8, 16 or 32 bits of the sampled lines. `bus_a_lo` starts at address bits [2:0] and advances, modulo 8, by 1, 2 or 4 after each sample.
- R9: A width field of 3 (reserved) is handled as 8-bit. `width_err` is then 1 from the address cycle until the next request is accepted, and it is 0 for any legal width.
- R10: A write with `cfg_we` at byte offset 8·n (n = 0..4) replaces the register of chip select n. Writes to other offsets change nothing. A read uses the register value held when it was accepted, so a write during a read affects only later reads.
- R11: Each sample yields one `rsp_valid` pulse in the following cycle, taken while the chip select is low. `rsp_last` marks the final beat, and output enable is already high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_ofs | input | 6 | Byte offset of the register written |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_cs | input | 3 | Chip-select index (0 = boot device). Indices above 4 assert no line and use register 0 |
| req_addr | input | 16 | Byte address |
| req_len | input | 3 | Burst beats minus one |
| rsp_valid | output | 1 | Sampled word valid (no back-pressure) |
| rsp_data | output | 32 | Sampled word, masked to device width |
| rsp_last | output | 1 | Final beat of the burst |
| width_err | output | 1 | Current read used the reserved width code |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_cs_n | output | 5 | Chip selects, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_a_lo | output | 3 | Low address bits for the current beat |
| bus_ad_oe | output | 1 | Drive enable for the address/data lines |
| bus_ad_out | output | 32 | Value driven on the address/data lines |
| bus_ad_in | input | 32 | Value observed on the address/data lines |

## Verification
Most internal state shows up at the device pins within a single read. If the wait counter is wrong, the sampled cycle-stamp byte in `rsp_data` is wrong on the first beat. If the beat counter is wrong, the count of responses and the position of `rsp_last` are wrong. If the address step is wrong, the `bus_a_lo` byte of the next 16- or 32-bit beat is wrong. If the tail counter is wrong, the chip-select rise cycle changes, or the gap to the next address cycle changes, and this shows up in the read that follows. A register latched at the wrong time only shows when a write lands during a read and the next read repeats the old timing.

// File: rtl/pbus_rd_pkg.sv
package pbus_rd_pkg;

  // One chip select's read timing word, most significant field first.
  typedef struct packed {
    logic [1:0] width;
    logic [1:0] skew;
    logic [4:0] hold;
    logic [5:0] nxt;
    logic [4:0] setup;
    logic [5:0] first;
    logic [5:0] turn;
  } rd_timing_t;

  typedef enum logic [1:0] {
    DW_8   = 2'd0,
    DW_16  = 2'd1,
    DW_32  = 2'd2,
    DW_RSV = 2'd3
  } dev_width_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALE,
    ST_ACC,
    ST_TAIL
  } seq_state_e;

  localparam logic [5:0] MIN_FIRST = 6'd6;
  localparam logic [5:0] MIN_NEXT  = 6'd2;
  localparam logic [5:0] MIN_TURN  = 6'd2;

  function automatic logic [5:0] at_least(input logic [5:0] v, input logic [5:0] lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/pbus_rd_regs.sv
module pbus_rd_regs #(
  parameter int          NUM_CS  = 5,
  parameter int          OFS_W   = 6,
  parameter logic [31:0] RST_VAL = 32'h4084_0182
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [OFS_W-1:0]         ofs,
  input  logic [31:0]              wdata,
  output logic [NUM_CS-1:0][31:0]  regs
);

  // One register per chip select, spaced eight bytes apart.
  for (genvar i = 0; i < NUM_CS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= RST_VAL;
      else if (we && ofs == OFS_W'(8 * i))
        regs[i] <= wdata;
    end
  end

endmodule

// File: rtl/pbus_rd_engine.sv
module pbus_rd_engine
  import pbus_rd_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NUM_CS-1:0] req_cs_oh,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  rd_timing_t        tim,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_last,
  output logic              width_err,
  output logic              bus_ale,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic              bus_oe_n,
  output logic [2:0]        bus_a_lo,
  output logic              bus_ad_oe,
  output logic [31:0]       bus_ad_out,
  input  logic [31:0]       bus_ad_in
);

  seq_state_e        state;
  logic [NUM_CS-1:0] cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [5:0]        wait_cnt, next_q, tail_cnt, tail_end_q;
  logic [4:0]        setup_cnt, hold_q;
  logic [LEN_W-1:0]  beats_left;
  logic [2:0]        a_lo, step_q;
  logic [31:0]       mask_q;
  logic              werr_q;

  // Effective (clamped) timing of the request on offer.
  logic [5:0]  eff_first, eff_next, eff_turn, eff_end, hold_ext;
  dev_width_e  eff_width;
  logic [2:0]  eff_step;
  logic [31:0] eff_mask;
  logic        unused_skew;

  assign unused_skew = ^tim.skew;
  assign eff_first   = at_least(tim.first, MIN_FIRST);
  assign eff_next    = at_least(tim.nxt, MIN_NEXT);
  assign eff_turn    = at_least(tim.turn, MIN_TURN);
  assign hold_ext    = {1'b0, tim.hold};
  assign eff_end     = (eff_turn > hold_ext) ? eff_turn : hold_ext;

  always_comb begin
    eff_width = dev_width_e'(tim.width);
    if (eff_width == DW_RSV) eff_width = DW_8;
    case (eff_width)
      DW_16:   begin eff_step = 3'd2; eff_mask = 32'h0000_FFFF; end
      DW_32:   begin eff_step = 3'd4; eff_mask = 32'hFFFF_FFFF; end
      default: begin eff_step = 3'd1; eff_mask = 32'h0000_00FF; end
    endcase
  end

  logic accept, sample_now;
  assign accept     = req_valid && (state == ST_IDLE);
  assign sample_now = (state == ST_ACC) && (wait_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cs_q       <= '0;
      addr_q     <= '0;
      wait_cnt   <= '0;
      next_q     <= '0;
      tail_cnt   <= '0;
      tail_end_q <= '0;
      setup_cnt  <= '0;
      hold_q     <= '0;
      beats_left <= '0;
      a_lo       <= '0;
      step_q     <= '0;
      mask_q     <= '0;
      werr_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_last   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (state == ST_ALE || state == ST_ACC)
        if (setup_cnt != '0) setup_cnt <= setup_cnt - 5'd1;
      case (state)
        ST_IDLE: if (accept) begin
          state      <= ST_ALE;
          cs_q       <= req_cs_oh;
          addr_q     <= req_addr;
          wait_cnt   <= eff_first - 6'd3;
          next_q     <= eff_next;
          setup_cnt  <= tim.setup;
          hold_q     <= tim.hold;
          tail_end_q <= eff_end;
          beats_left <= req_len;
          a_lo       <= req_addr[2:0];
          step_q     <= eff_step;
          mask_q     <= eff_mask;
          werr_q     <= (tim.width == DW_RSV);
        end
        ST_ALE: state <= ST_ACC;
        ST_ACC: begin
          if (sample_now) begin
            rsp_valid <= 1'b1;
            rsp_data  <= bus_ad_in & mask_q;
            rsp_last  <= (beats_left == '0);
            a_lo      <= a_lo + step_q;
            if (beats_left == '0) begin
              state    <= ST_TAIL;
              tail_cnt <= 6'd1;
            end else begin
              beats_left <= beats_left - 1'b1;
              wait_cnt   <= next_q - 6'd1;
            end
          end else begin
            wait_cnt <= wait_cnt - 6'd1;
          end
        end
        default: begin
          if (tail_cnt == tail_end_q - 6'd1) state <= ST_IDLE;
          else tail_cnt <= tail_cnt + 6'd1;
        end
      endcase
    end
  end

  logic cs_on, oe_on;
  assign cs_on = (state == ST_ALE) || (state == ST_ACC) ||
                 ((state == ST_TAIL) && (tail_cnt < {1'b0, hold_q}));
  assign oe_on = ((state == ST_ALE) || (state == ST_ACC)) && (setup_cnt == '0);

  assign req_ready  = (state == ST_IDLE);
  assign bus_ale    = (state == ST_ALE);
  assign bus_ad_oe  = (state == ST_ALE);
  assign bus_ad_out = bus_ale ? 32'(addr_q) : '0;
  assign bus_cs_n   = ~(cs_on ? cs_q : '0);
  assign bus_oe_n   = ~oe_on;
  assign bus_a_lo   = a_lo;
  assign width_err  = werr_q;

endmodule

// File: rtl/pbus_rd_seq.sv
module pbus_rd_seq
  import pbus_rd_pkg::*;
#(
  parameter int          NUM_CS     = 5,
  parameter int          ADDR_W     = 16,
  parameter int          LEN_W      = 3,
  parameter logic [31:0] RST_TIMING = 32'h4084_0182,
  localparam int         OFS_W      = $clog2(8 * NUM_CS),
  localparam int         CS_W       = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OFS_W-1:0]  cfg_ofs,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_last,
  output logic              width_err,
  output logic              bus_ale,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic              bus_oe_n,
  output logic [2:0]        bus_a_lo,
  output logic              bus_ad_oe,
  output logic [31:0]       bus_ad_out,
  input  logic [31:0]       bus_ad_in
);

  logic [NUM_CS-1:0][31:0] regs;
  logic [NUM_CS-1:0]       cs_oh;
  logic                    cs_ok;
  rd_timing_t              tim_sel;

  pbus_rd_regs #(.NUM_CS(NUM_CS), .OFS_W(OFS_W), .RST_VAL(RST_TIMING)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .ofs(cfg_ofs), .wdata(cfg_wdata),
    .regs(regs)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_dec
    assign cs_oh[i] = (req_cs == CS_W'(i));
  end

  assign cs_ok   = (req_cs < CS_W'(NUM_CS));
  assign tim_sel = rd_timing_t'(cs_ok ? regs[req_cs] : regs[0]);

  pbus_rd_engine #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs_oh(cs_oh),
    .req_addr(req_addr), .req_len(req_len), .tim(tim_sel),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .width_err(width_err),
    .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_a_lo(bus_a_lo), .bus_ad_oe(bus_ad_oe), .bus_ad_out(bus_ad_out),
    .bus_ad_in(bus_ad_in)
  );

endmodule

// File: rtl/pbus_rd_chk.sv
module pbus_rd_chk #(
  parameter int NUM_CS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_last,
  input logic              bus_ale,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_oe_n,
  input logic              bus_ad_oe
);

  logic [3:0] since_ale, since_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ale  <= 4'd0;
      since_last <= 4'hF;
    end else begin
      if (bus_ale) since_ale <= 4'd1;
      else if (since_ale != 4'hF) since_ale <= since_ale + 4'd1;
      if (rsp_valid && rsp_last) since_last <= 4'd1;
      else if (since_last != 4'hF) since_last <= since_last + 4'd1;
    end
  end

  a_r2_one_cs_at_most: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  a_r2_drive_only_in_addr_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> bus_ale);
  a_r2_ready_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&bus_cs_n && bus_oe_n && !bus_ale));
  // since_ale is 1 in the cycle after the address cycle; first sample at >= 4, response at >= 5.
  a_r3_first_sample_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (since_ale >= 4'd5));
  a_r6_oe_high_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |-> bus_oe_n);
  a_r6_oe_rise_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_n) |-> (rsp_valid && rsp_last));
  a_r7_turnaround_floor: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (since_last >= 4'd2));
  a_r11_sample_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!(&bus_cs_n)));

endmodule

bind pbus_rd_seq pbus_rd_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_last(rsp_last), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
  .bus_oe_n(bus_oe_n), .bus_ad_oe(bus_ad_oe)
);

// File: tb/sim_pbus_rd_seq.sv
module sim_pbus_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_T = 32'h4084_0182;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cs = '0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_len = '0;
  logic        rsp_valid, rsp_last, width_err;
  logic [31:0] rsp_data;
  logic        bus_ale, bus_oe_n, bus_ad_oe;
  logic [4:0]  bus_cs_n;
  logic [2:0]  bus_a_lo;
  logic [31:0] bus_ad_out, bus_ad_in;

  pbus_rd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs), .req_addr(req_addr),
    .req_len(req_len), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .width_err(width_err), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_a_lo(bus_a_lo), .bus_ad_oe(bus_ad_oe), .bus_ad_out(bus_ad_out),
    .bus_ad_in(bus_ad_in)
  );

  // Device model: latches the address, returns {address, a_lo byte, cycle stamp}.
  logic [15:0] dev_addr = '0;
  logic [7:0]  dev_cnt = '0;
  always @(posedge clk) begin
    if (bus_ale) begin
      dev_addr <= bus_ad_out[15:0];
      dev_cnt  <= 8'd1;
    end else begin
      dev_cnt <= dev_cnt + 8'd1;
    end
  end
  assign bus_ad_in = {dev_addr, 5'b0, bus_a_lo, dev_cnt};

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] d;
    bit          last;
    string       tag;
  } beat_t;

  typedef struct {
    int    oe_lo, oe_hi, cs_hi, gap, cs, addr;
    bit    b2b, werr;
    string tag;
  } txn_t;

  beat_t beat_q[$];
  txn_t  txn_q[$];
  logic [31:0] shadow [5];

  function automatic logic [31:0] mk(input int w, input int hold, input int nxt,
                                     input int setup, input int first, input int turn);
    return {w[1:0], 2'b01, hold[4:0], nxt[5:0], setup[4:0], first[5:0], turn[5:0]};
  endfunction

  function automatic int lim(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  task automatic cfg_write(input int ofs, input logic [31:0] val);
    cfg_we = 1'b1; cfg_ofs = ofs[5:0]; cfg_wdata = val;
    if (ofs % 8 == 0 && ofs / 8 < 5) shadow[ofs / 8] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: computes the expected words and pin timing, then issues the request.
  task automatic do_read(input int cs, input logic [15:0] addr, input int len, input string tag);
    logic [31:0] r;
    int w, first, nxt, turn, hold, setup, step, cnt, alo, lcyc;
    logic [31:0] full, m;
    txn_t t;
    r = shadow[cs];
    w = int'(r[31:30]); hold = int'(r[27:23]); setup = int'(r[16:12]);
    first = lim(int'(r[11:6]), 6); nxt = lim(int'(r[22:17]), 2); turn = lim(int'(r[5:0]), 2);
    if (w == 3) w = 0;
    step = 1 << w;
    m = (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    for (int b = 0; b <= len; b++) begin
      beat_t e;
      cnt  = first - 2 + b * nxt;
      alo  = (int'(addr[2:0]) + b * step) % 8;
      full = {addr, 5'b0, alo[2:0], cnt[7:0]};
      e.d = full & m; e.last = (b == len); e.tag = tag;
      beat_q.push_back(e);
    end
    lcyc    = first - 2 + len * nxt;
    t.oe_lo = setup;
    t.oe_hi = lcyc + 1;
    t.cs_hi = lcyc + ((hold > 1) ? hold : 1);
    t.gap   = lcyc + ((turn > hold) ? turn : hold) + 1;
    t.cs    = cs; t.addr = int'(addr);
    t.werr  = (r[31:30] == 2'd3);
    t.b2b   = !req_ready;
    t.tag   = tag;
    txn_q.push_back(t);
    req_valid = 1'b1; req_cs = cs[2:0]; req_addr = addr; req_len = len[2:0];
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard as the design produces responses and pin edges.
  txn_t cur;
  bit   have_cur = 1'b0, seen_oe = 1'b0, prev_oe = 1'b1;
  logic [4:0] prev_cs = 5'h1F;
  int   rel = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (beat_q.size() == 0) begin
          chk(1'b0, "R11 response with none expected", rsp_data, 0);
        end else begin
          beat_t e;
          e = beat_q.pop_front();
          chk(rsp_data == e.d, {e.tag, " R3 R4 R8 sampled word"}, rsp_data, e.d);
          chk(rsp_last == e.last, {e.tag, " R4 R11 last flag"}, rsp_last, e.last);
        end
      end
      if (bus_ale) begin
        if (txn_q.size() == 0) begin
          chk(1'b0, "R2 address cycle with no request", 1, 0);
        end else begin
          txn_t nt;
          nt = txn_q.pop_front();
          if (have_cur) begin
            if (nt.b2b) chk(rel == cur.gap, {nt.tag, " R7 address cycle spacing"}, rel, cur.gap);
            else        chk(rel >= cur.gap, {nt.tag, " R7 turnaround floor"}, rel, cur.gap);
          end
          cur = nt; have_cur = 1'b1; rel = 0; seen_oe = 1'b0;
          chk(bus_ad_oe && bus_ad_out == 32'(cur.addr), {cur.tag, " R2 address drive"},
              bus_ad_out, cur.addr);
          chk(~bus_cs_n == 5'(1 << cur.cs), {cur.tag, " R2 chip select"}, ~bus_cs_n, 1 << cur.cs);
          chk(width_err == cur.werr, {cur.tag, " R9 width error flag"}, width_err, cur.werr);
        end
      end
      if (have_cur) begin
        if (!bus_oe_n && !seen_oe) begin
          seen_oe = 1'b1;
          chk(rel == cur.oe_lo, {cur.tag, " R5 output enable fall"}, rel, cur.oe_lo);
        end
        if (bus_oe_n && !prev_oe)
          chk(rel == cur.oe_hi, {cur.tag, " R6 output enable rise"}, rel, cur.oe_hi);
        if (bus_cs_n[cur.cs] && !prev_cs[cur.cs])
          chk(rel == cur.cs_hi, {cur.tag, " R6 chip select rise"}, rel, cur.cs_hi);
      end
      if (bus_ad_oe && !bus_ale) chk(1'b0, "R2 bus driven outside address cycle", 1, 0);
      prev_oe = bus_oe_n;
      prev_cs = bus_cs_n;
      if (rel < 100000) rel++;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) shadow[i] = RST_T;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(bus_cs_n == 5'h1F, "R1 chip selects idle", bus_cs_n, 5'h1F);
    chk(bus_oe_n == 1'b1, "R1 output enable idle", bus_oe_n, 1);
    chk(!bus_ale && !bus_ad_oe, "R1 strobe and drive off", {bus_ale, bus_ad_oe}, 0);
    chk(!rsp_valid && !width_err, "R1 no response or error", {rsp_valid, width_err}, 0);

    // Reset timing on the boot chip select, single beat (R1 register default).
    do_read(0, 16'h1234, 0, "R1");
    // 32-bit device, burst of 4, address bits wrap (R8).
    cfg_write(8,  mk(2, 4, 3, 2, 10, 5));
    do_read(1, 16'h0104, 3, "R8");
    // Values below the floors get clamped (R3 R4 R7).
    cfg_write(16, mk(0, 0, 0, 1, 3, 0));
    do_read(2, 16'h0007, 2, "R3");
    // Reserved width, hold longer than turnaround (R9 R7).
    cfg_write(24, mk(3, 7, 4, 5, 8, 3));
    do_read(3, 16'h00A1, 1, "R9");
    // 16-bit device, long burst; error flag back to 0 (R9).
    cfg_write(32, mk(1, 2, 5, 3, 20, 4));
    do_read(4, 16'h00F6, 7, "R9");
    // Write during a read reaches only the next read (R10).
    do_read(1, 16'h0200, 1, "R10");
    cfg_write(8, mk(1, 0, 2, 0, 7, 2));
    do_read(1, 16'h0202, 1, "R10");
    // Non-register offsets are ignored (R10).
    cfg_write(4,  32'hFFFF_FFFF);
    cfg_write(40, 32'h0000_0000);
    do_read(0, 16'h0033, 2, "R10");

    repeat (200) @(negedge clk);
    chk(beat_q.size() == 0, "R11 all responses delivered", beat_q.size(), 0);
    chk(txn_q.size() == 0, "R2 all address cycles seen", txn_q.size(), 0);
    chk(req_ready && bus_cs_n == 5'h1F, "R7 back to idle", {req_ready, bus_cs_n}, 6'h3F);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule